// File: doc/BRIEF.md
# Fullwave Rectifier with Boxcar Lowpass

This block takes a stream of 16-bit signed audio samples and folds every negative sample onto the positive side. It doubles the folded value and shifts it back into signed range, so the full output swing is used again. The result then goes through a boxcar (moving-average) lowpass filter. The filter keeps a running sum of the most recent 2^k rectified samples, and divides it by a right shift of k bits. The filtered sample leaves on an output stream, one output for every accepted input.

Samples arrive on a valid/ready input and leave on a valid/ready output that is backed by one register. The input is ready whenever the output register is empty or is being drained in the same cycle. While the consumer holds `m_ready` low, the output word stays frozen and the input is stalled, so no sample is lost or dropped. A plain 3-bit control input `cut_idx` selects k. A change of that value, or a pulse on `flush`, wipes the sample history and the running sum one entry per clock. `busy` is high while this happens. A sample that is accepted during the wipe gives a zero output and never enters the history.

Top module: `fwr_boxcar_filter`

## Requirements
- R1: A sample with bit 15 set is folded by inverting all 16 bits (ones complement), so 0x8000 folds to 0x7FFF and 0xFFFF folds to 0x0000.
- R2: The folded value is shifted left by one bit and 0x8000 is added modulo 2^16. With k = 0, the inputs 0x0000, 0x7FFF, 0x1234, 0x8000 and 0xFFFF give 0x8000, 0x7FFE, 0xA468, 0x7FFE and 0x8000.
- R3: Each output equals the sum of the last 2^k rectified samples taken as signed values, with missing history counting as zero, arithmetically shifted right by k bits; the low 16 bits are output. This holds up to the largest window of 64 samples, including wraparound of the history.
- R4: With k = 0 the output equals the rectified value of the same sample.
- R5: After reset, `m_valid` is 0, k is 3 (an 8-sample window) and `busy` is 1. `busy` falls at the 64th rising edge after reset release.
- R6: When the clamped `cut_idx` differs from the current k, the block loads the new k. It raises `busy` for exactly 64 cycles and restarts the filter from an all-zero history.
- R7: A `flush` pulse raises `busy` on the next cycle for exactly 64 cycles. After it, the filter restarts from an all-zero history with k unchanged.
- R8: A sample accepted while `busy` is high gives an output of 0x0000 and leaves no trace in later outputs.
- R9: A `cut_idx` value of 7 acts as 6. Moving from 6 to 7 starts no clear.
- R10: While `m_valid` is 1 and `m_ready` is 0, `m_data` and `m_valid` hold and `s_ready` is 0.
- R11: Every accepted input gives exactly one output on the next cycle, and the outputs keep input order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Input sample is valid |
| s_ready | output | 1 | Block can accept a sample this cycle |
| s_data | input | 16 | Signed input sample |
| m_valid | output | 1 | Output sample is valid |
| m_ready | input | 1 | Consumer accepts the output sample |
| m_data | output | 16 | Signed filtered sample |
| cut_idx | input | 3 | Window exponent k (window 2^k, 7 treated as 6) |
| flush | input | 1 | Pulse to wipe history and running sum |
| busy | output | 1 | History wipe in progress |

## Verification
Suppose a history entry is left stale by an incomplete wipe, or the oldest-sample pointer sits at the wrong distance. The running sum then drifts, and the fault shows in `m_data` one cycle after the first sample whose window touches that entry. It also persists, because the wrong subtraction is never undone. The bench models the window sum on its own and compares every output, with random back-pressure. It also measures how long `busy` stays high, and runs a 64-sample window well past wraparound. A fold or rebias error shows in the very next output when k = 0.

// File: rtl/fwr_pkg.sv
`timescale 1ns/1ps
package fwr_pkg;

  // Operating mode of the history wipe sequencer.
  typedef enum logic [0:0] {
    FILL_RUN   = 1'b0,
    FILL_CLEAR = 1'b1
  } fill_mode_e;

endpackage

// File: rtl/fwr_rectify.sv
`timescale 1ns/1ps
// Fold negative samples by ones complement, double, and rebias to signed.
module fwr_rectify #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  localparam logic [DATA_W-1:0] BIAS = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0] folded;

  always_comb begin
    folded = din[DATA_W-1] ? ~din : din;
    dout   = {folded[DATA_W-2:0], 1'b0} + BIAS;
  end

endmodule

// File: rtl/fwr_clear_ctrl.sv
`timescale 1ns/1ps
// Holds the window exponent and sequences the one-entry-per-clock wipe.
module fwr_clear_ctrl
  import fwr_pkg::*;
#(
  parameter int CUT_W     = 3,
  parameter int MAX_CUT   = 6,
  parameter int RESET_CUT = 3,
  parameter int AW        = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CUT_W-1:0] cut_req,
  input  logic             flush,
  output logic [CUT_W-1:0] cur_cut,
  output logic             busy,
  output logic [AW-1:0]    clr_addr
);

  localparam logic [CUT_W-1:0] CUT_LIM  = CUT_W'(MAX_CUT);
  localparam logic [CUT_W-1:0] CUT_INIT = CUT_W'(RESET_CUT);
  localparam logic [AW-1:0]    LAST     = {AW{1'b1}};

  fill_mode_e       mode;
  logic [CUT_W-1:0] cut_sel;
  logic             restart;

  always_comb begin
    cut_sel = (cut_req > CUT_LIM) ? CUT_LIM : cut_req;
    restart = flush || (cut_sel != cur_cut);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= FILL_CLEAR;
      cur_cut  <= CUT_INIT;
      clr_addr <= '0;
    end else if (restart) begin
      mode     <= FILL_CLEAR;
      cur_cut  <= cut_sel;
      clr_addr <= '0;
    end else if (mode == FILL_CLEAR) begin
      clr_addr <= clr_addr + AW'(1);
      if (clr_addr == LAST) begin
        mode <= FILL_RUN;
      end
    end
  end

  assign busy = (mode == FILL_CLEAR);

endmodule

// File: rtl/fwr_history.sv
`timescale 1ns/1ps
// Circular sample store: one synchronous write port, one combinational read.
module fwr_history #(
  parameter int DATA_W = 16,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/fwr_accum.sv
`timescale 1ns/1ps
// Running window sum: add newest, subtract the sample that leaves, scale.
module fwr_accum #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32,
  parameter int CUT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic [DATA_W-1:0] add_val,
  input  logic [DATA_W-1:0] sub_val,
  input  logic [CUT_W-1:0]  shift,
  output logic [DATA_W-1:0] avg
);

  localparam int EXT_W = ACC_W - DATA_W;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_d;
  logic signed [ACC_W-1:0] add_ext;
  logic signed [ACC_W-1:0] sub_ext;
  logic signed [ACC_W-1:0] scaled;

  always_comb begin
    add_ext = {{EXT_W{add_val[DATA_W-1]}}, add_val};
    sub_ext = {{EXT_W{sub_val[DATA_W-1]}}, sub_val};
    acc_d   = acc_q + add_ext - sub_ext;
    scaled  = acc_d >>> shift;
    avg     = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clr) begin
      acc_q <= '0;
    end else if (upd) begin
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/fwr_boxcar_filter.sv
`timescale 1ns/1ps
// Top: stream wrapper around rectifier, history store and window sum.
module fwr_boxcar_filter #(
  parameter int DATA_W    = 16,
  parameter int ACC_W     = 32,
  parameter int CUT_W     = 3,
  parameter int MAX_CUT   = 6,
  parameter int RESET_CUT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  input  logic [CUT_W-1:0]  cut_idx,
  input  logic              flush,
  output logic              busy
);

  localparam int AW = (MAX_CUT < 1) ? 1 : MAX_CUT;

  logic              accept;
  logic              run_acc;
  logic [DATA_W-1:0] rect_w;
  logic [DATA_W-1:0] old_w;
  logic [DATA_W-1:0] avg_w;
  logic [CUT_W-1:0]  cur_cut;
  logic [AW-1:0]     clr_addr;
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     rd_ptr;
  logic [AW:0]       win_len;
  logic              hist_we;
  logic [AW-1:0]     hist_addr;
  logic [DATA_W-1:0] hist_wdata;

  assign s_ready = !m_valid || m_ready;
  assign accept  = s_valid && s_ready;
  assign run_acc = accept && !busy;

  // The oldest sample sits exactly one window behind the write pointer.
  always_comb begin
    win_len = (AW + 1)'(1) << cur_cut;
    rd_ptr  = wr_ptr - win_len[AW-1:0];
  end

  // The wipe owns the write port while busy.
  always_comb begin
    if (busy) begin
      hist_we    = 1'b1;
      hist_addr  = clr_addr;
      hist_wdata = '0;
    end else begin
      hist_we    = accept;
      hist_addr  = wr_ptr;
      hist_wdata = rect_w;
    end
  end

  fwr_rectify #(.DATA_W(DATA_W)) u_rect (
    .din  (s_data),
    .dout (rect_w)
  );

  fwr_clear_ctrl #(
    .CUT_W    (CUT_W),
    .MAX_CUT  (MAX_CUT),
    .RESET_CUT(RESET_CUT),
    .AW       (AW)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .cut_req (cut_idx),
    .flush   (flush),
    .cur_cut (cur_cut),
    .busy    (busy),
    .clr_addr(clr_addr)
  );

  fwr_history #(.DATA_W(DATA_W), .AW(AW)) u_hist (
    .clk  (clk),
    .we   (hist_we),
    .waddr(hist_addr),
    .wdata(hist_wdata),
    .raddr(rd_ptr),
    .rdata(old_w)
  );

  fwr_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W), .CUT_W(CUT_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (busy),
    .upd    (run_acc),
    .add_val(rect_w),
    .sub_val(old_w),
    .shift  (cur_cut),
    .avg    (avg_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
    end else if (busy) begin
      wr_ptr <= '0;
    end else if (accept) begin
      wr_ptr <= wr_ptr + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (accept) begin
      m_valid <= 1'b1;
      m_data  <= busy ? '0 : avg_w;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/fwr_boxcar_filter_chk.sv
`timescale 1ns/1ps
module fwr_boxcar_filter_chk #(
  parameter int DATA_W = 16,
  parameter int CUT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic [DATA_W-1:0] s_data,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic [CUT_W-1:0]  cut_idx,
  input logic              flush,
  input logic              busy
);

  // Independent statement of the fold-double-rebias rule.
  function automatic logic [DATA_W-1:0] fold_ref(input logic [DATA_W-1:0] x);
    logic [DATA_W-1:0] mag;
    mag = x[DATA_W-1] ? (DATA_W'(0) - x - DATA_W'(1)) : x;
    return (mag << 1) ^ (DATA_W'(1) << (DATA_W - 1));
  endfunction

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);

  assert_one_out_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> m_valid);

  assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_valid && !(s_valid && s_ready)) |=> !m_valid);

  assert_busy_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && busy) |=> (m_valid && m_data == '0));

  assert_flush_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> busy);

  assert_unit_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !busy && cut_idx == '0 && $past(cut_idx) == '0)
    |=> (m_data == fold_ref($past(s_data))));

endmodule

bind fwr_boxcar_filter fwr_boxcar_filter_chk #(
  .DATA_W(DATA_W),
  .CUT_W (CUT_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .s_valid(s_valid),
  .s_ready(s_ready),
  .s_data (s_data),
  .m_valid(m_valid),
  .m_ready(m_ready),
  .m_data (m_data),
  .cut_idx(cut_idx),
  .flush  (flush),
  .busy   (busy)
);

// File: tb/fwr_boxcar_filter_bench.sv
`timescale 1ns/1ps
module fwr_boxcar_filter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_data = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [15:0] m_data;
  logic [2:0]  cut_idx = 3'd3;
  logic        flush = 1'b0;
  logic        busy;

  int n_checks = 0;
  int n_fails  = 0;
  bit bp_on    = 1'b0;
  bit finished = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  int          hist_m[$];
  int          model_cut = 3;

  always #2.5 clk = ~clk;

  fwr_boxcar_filter u_fwr_boxcar_filter (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_valid(s_valid),
    .s_ready(s_ready),
    .s_data (s_data),
    .m_valid(m_valid),
    .m_ready(m_ready),
    .m_data (m_data),
    .cut_idx(cut_idx),
    .flush  (flush),
    .busy   (busy)
  );

  function automatic int rect_model(logic [15:0] d);
    int v;
    v = int'($signed(d));
    if (v < 0) v = -v - 1;
    return 2 * v - 32768;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: offers one sample, records the expected output once accepted.
  task automatic send(logic [15:0] d, string tag);
    bit          bz;
    longint      sum;
    longint      sh;
    logic [15:0] e;
    int          n;
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = d;
    #1;
    while (!s_ready) begin
      @(negedge clk);
      #1;
    end
    bz = busy;
    @(posedge clk);
    if (bz) begin
      e = 16'h0000;
    end else begin
      hist_m.push_back(rect_model(d));
      if (hist_m.size() > 64) void'(hist_m.pop_front());
      n   = 1 << model_cut;
      sum = 0;
      for (int i = 0; i < n && i < hist_m.size(); i++)
        sum += longint'(hist_m[hist_m.size() - 1 - i]);
      sh = sum >>> model_cut;
      e  = sh[15:0];
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic count_busy(output int c);
    c = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (busy) c++;
      else break;
    end
  endtask

  task automatic set_cut(logic [2:0] c, string tag);
    int  newc;
    int  cnt;
    bit  changed;
    @(negedge clk);
    s_valid = 1'b0;
    cut_idx = c;
    newc    = (c > 3'd6) ? 6 : int'(c);
    changed = (newc != model_cut);
    if (changed) begin
      model_cut = newc;
      hist_m.delete();
    end
    count_busy(cnt);
    check(cnt == (changed ? 64 : 0), tag, cnt, changed ? 64 : 0);
  endtask

  task automatic flush_start();
    @(negedge clk);
    s_valid = 1'b0;
    flush   = 1'b1;
    hist_m.delete();
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
  endtask

  // Monitor: drives back-pressure and compares every output with the queue.
  logic [15:0] held_data;
  bit          held = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        m_ready = bp_on ? ($urandom_range(2) != 0) : 1'b1;
        if (held) begin
          check(m_valid && (m_data == held_data), "R10 hold", int'(m_data), int'(held_data));
        end
        held      = m_valid && !m_ready;
        held_data = m_data;
        if (m_valid && m_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R11 unexpected output", int'(m_data), 0);
          end else begin
            logic [15:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(m_data === e, t, int'(m_data), int'(e));
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog R11 actual=%0d expected=%0d", exp_q.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (4) @(negedge clk);
    check(m_valid == 1'b0, "R5 reset m_valid", int'(m_valid), 0);
    check(busy == 1'b1, "R5 reset busy", int'(busy), 1);
    rst_n = 1'b1;
    // busy is seen high after rising edges 1..63 and low after the 64th
    count_busy(cnt);
    check(cnt == 63, "R5 reset clear length", cnt, 63);
    check(s_ready == 1'b1, "R5 s_ready after reset", int'(s_ready), 1);

    // R5: default 8-sample window, constant input ramps up over 8 outputs
    for (int i = 0; i < 12; i++) send(16'h6000, "R5 default window");

    // R3: varied data, window 8
    for (int i = 0; i < 20; i++) send(16'($urandom), "R3 window8");

    // R6 + R4 + R1 + R2: unit window
    set_cut(3'd0, "R6 clear on cut change");
    send(16'h8000, "R1 most negative");
    send(16'hFFFF, "R1 minus one");
    send(16'h0000, "R2 zero");
    send(16'h7FFF, "R2 max positive");
    send(16'h1234, "R2 mid value");
    for (int i = 0; i < 10; i++) send(16'($urandom), "R4 unit window");

    // R3 with back-pressure, largest window and wraparound
    bp_on = 1'b1;
    set_cut(3'd6, "R6 clear to window64");
    for (int i = 0; i < 150; i++) send(16'($urandom), "R3 window64 wrap");

    // R9: 7 acts as 6, no clear, window stays 64
    set_cut(3'd7, "R9 no clear on 7");
    for (int i = 0; i < 10; i++) send(16'($urandom), "R9 window stays 64");

    // R7: flush keeps window, restarts history
    flush_start();
    cnt = busy ? 1 : 0;
    begin
      int rest;
      count_busy(rest);
      cnt += rest;
    end
    check(cnt == 64, "R7 flush length", cnt, 64);
    for (int i = 0; i < 10; i++) send(16'h2000 + 16'(i), "R7 after flush");

    // R8: samples during a wipe give zero and are forgotten
    set_cut(3'd2, "R6 clear to window4");
    flush_start();
    for (int i = 0; i < 6; i++) send(16'h7FFF, "R8 during busy");
    @(negedge clk);
    s_valid = 1'b0;
    wait_idle();
    for (int i = 0; i < 8; i++) send(16'h0100 * 16'(i + 1), "R8 after busy");

    bp_on = 1'b0;
    set_cut(3'd1, "R6 clear to window2");
    for (int i = 0; i < 12; i++) send(16'($urandom), "R3 window2");
    @(negedge clk);
    s_valid = 1'b0;

    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, "R11 all outputs seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule